// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog timer attached to a simple register bus with single-cycle reads and writes. Software selects one of sixteen timeout ranges, sets the enable bit, and must then keep feeding the watchdog. A feed is a write to the restart register whose low byte carries the key 0x76. While the watchdog runs, a down-counter drops by one every clock. A valid feed reloads the counter with the value of the selected range. Any other value written to the restart register leaves the counter alone.

If the counter reaches zero, the block responds in one of two ways. In direct mode it drives the system reset output for a programmable number of clocks. In two-stage mode the first expiry raises an interrupt and reloads the counter. If the counter then expires again while that interrupt is still pending, the block asserts system reset. Software can read the live count and the interrupt status. It clears the interrupt by reading the clear register or by a valid feed. Once the enable bit is set, only a block reset can clear it.

Top module: `wdog_timer`

## Requirements
- R1: After reset, and for as long as the watchdog stays disabled, the counter reads 2^BASE_LOG-1 and the control, range and status registers read zero. The interrupt and system reset outputs stay low during this time.
- R2: The register offsets are: 0x00 control, 0x04 range, 0x08 count (read-only), 0x0C restart, 0x10 status and 0x14 clear. The control fields are bit 0 enable, bit 1 mode and bits 4:2 the pulse code. The range field is bits 3:0. Status bit 0 is the pending interrupt. Undefined offsets and the clear register read as zero.
- R3: Writing 0 to control bit 0 after the watchdog is enabled leaves it enabled. Only the block reset disables it.
- R4: Setting the enable bit loads the counter with 2^(BASE_LOG+i)-1, where i is the current range index. From the next clock on, the counter drops by one per clock.
- R5: A restart write reloads the counter only when data bits 7:0 equal 0x76, whatever the upper bits hold. Any other low byte leaves the counter decrementing.
- R6: Writing a new range index does not change the running count. The new value is used at the next reload.
- R7: In mode 0, a counter that holds zero raises system reset on the following clock. The output stays high for 2^(code+1) clocks, and the counter holds at zero meanwhile.
- R8: The clock after the reset pulse ends, the counter holds the reload value, and it keeps decrementing from there.
- R9: In mode 1, the first expiry with no interrupt pending sets the interrupt (status bit 0 and irq_o) and reloads the counter, without raising system reset.
- R10: In mode 1, an expiry while the interrupt is still pending raises the system reset pulse. The interrupt stays pending.
- R11: Reading the clear register clears the pending interrupt from the next clock on. A valid keyed restart also clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as the access |
| irq_o | output | 1 | Pending watchdog interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The assertions assume the following about the inputs. The reset is synchronous. Bus inputs are stable across each rising edge. The mode bit is not rewritten in the same cycle the counter expires, because the two-stage check compares the reset pulse with the interrupt state one cycle before. The stimulus changes inputs only on falling edges and holds each access for exactly one cycle. It writes the control register only while the count is far from zero. Every pulse code used is at least 0, which gives a pulse of two clocks or more, so the check that a pulse lasts beyond its first cycle holds.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    localparam int IDX_W  = 4;
    localparam int CODE_W = 3;

    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_RANGE = 'h04;
    localparam int OFS_COUNT = 'h08;
    localparam int OFS_FEED  = 'h0C;
    localparam int OFS_STAT  = 'h10;
    localparam int OFS_CLR   = 'h14;

    localparam logic [7:0] FEED_KEY = 8'h76;

    typedef struct packed {
        logic              en;
        logic              mode;
        logic [CODE_W-1:0] code;
        logic [IDX_W-1:0]  idx;
    } cfg_t;
endpackage

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs
    import wdog_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_ctrl,
    input  logic               wr_range,
    input  logic [CODE_W+1:0]  ctrl_bits,
    input  logic [IDX_W-1:0]   range_bits,
    output cfg_t               cfg,
    output logic               en_start
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d    = cfg_q;
        en_start = 1'b0;
        if (wr_ctrl) begin
            cfg_d.en   = cfg_q.en | ctrl_bits[0];
            cfg_d.mode = ctrl_bits[1];
            cfg_d.code = ctrl_bits[CODE_W+1:2];
            en_start   = ctrl_bits[0] & ~cfg_q.en;
        end
        if (wr_range) begin
            cfg_d.idx = range_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/wdog_pulse.sv
`timescale 1ns/1ps
module wdog_pulse #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              busy_o,
    output logic              done_o
);
    localparam int PCNT_W = 2 ** CODE_W;
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    typedef struct packed {
        logic              act;
        logic [PCNT_W-1:0] pcnt;
    } pst_t;

    pst_t s_d, s_q;

    function automatic logic [PCNT_W-1:0] len_of(input logic [CODE_W-1:0] c);
        logic [PCNT_W-1:0] ones;
        ones = '1;
        return ones >> (CODE_MAX - c);
    endfunction

    always_comb begin
        s_d = s_q;
        if (fire_i) begin
            s_d.act  = 1'b1;
            s_d.pcnt = len_of(code_i);
        end else if (s_q.act) begin
            if (s_q.pcnt == '0) s_d.act  = 1'b0;
            else                s_d.pcnt = s_q.pcnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign busy_o = s_q.act;
    assign done_o = s_q.act && (s_q.pcnt == '0);
endmodule

// File: rtl/wdog_count.sv
`timescale 1ns/1ps
module wdog_count
    import wdog_pkg::*;
#(
    parameter int BASE_LOG = 16,
    parameter int CNT_W    = BASE_LOG + 2 ** IDX_W - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             en_start,
    input  logic             mode,
    input  logic [IDX_W-1:0] idx,
    input  logic             feed_ok,
    input  logic             irq_clr,
    input  logic             busy,
    input  logic             done,
    output logic [CNT_W-1:0] cnt,
    output logic             irq,
    output logic             fire
);
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } cst_t;

    cst_t s_d, s_q;
    logic [CNT_W-1:0] reload;

    function automatic logic [CNT_W-1:0] reload_of(input logic [IDX_W-1:0] i);
        logic [CNT_W-1:0] ones;
        ones = '1;
        return ones >> (IDX_MAX - i);
    endfunction

    assign reload = reload_of(idx);

    always_comb begin
        s_d  = s_q;
        fire = 1'b0;
        if (irq_clr) s_d.irq = 1'b0;
        if (en_start) begin
            s_d.cnt = reload;
        end else if (en) begin
            if (feed_ok) s_d.irq = 1'b0;
            if (busy) begin
                if (done) s_d.cnt = reload;
            end else if (feed_ok) begin
                s_d.cnt = reload;
            end else if (s_q.cnt == '0) begin
                if (mode && !s_q.irq) begin
                    s_d.irq = 1'b1;
                    s_d.cnt = reload;
                end else begin
                    fire = 1'b1;
                end
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.cnt <= reload_of('0);
            s_q.irq <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt = s_q.cnt;
    assign irq = s_q.irq;
endmodule

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int BASE_LOG = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);
    localparam int CNT_W = BASE_LOG + 2 ** IDX_W - 1;

    cfg_t             cfg;
    logic             en_start;
    logic             wr_ctrl, wr_range, feed_ok, irq_clr;
    logic [CNT_W-1:0] cnt_val;
    logic             irq, fire, busy, done;
    logic             unused_hi;

    assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_range = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_RANGE));
    assign feed_ok  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_FEED))
                      && (bus_wdata[7:0] == FEED_KEY);
    assign irq_clr  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFS_CLR));
    assign unused_hi = ^bus_wdata[DATA_W-1:8];

    wdog_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_ctrl    (wr_ctrl),
        .wr_range   (wr_range),
        .ctrl_bits  (bus_wdata[CODE_W+1:0]),
        .range_bits (bus_wdata[IDX_W-1:0]),
        .cfg        (cfg),
        .en_start   (en_start)
    );

    wdog_count #(
        .BASE_LOG (BASE_LOG),
        .CNT_W    (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg.en),
        .en_start (en_start),
        .mode     (cfg.mode),
        .idx      (cfg.idx),
        .feed_ok  (feed_ok),
        .irq_clr  (irq_clr),
        .busy     (busy),
        .done     (done),
        .cnt      (cnt_val),
        .irq      (irq),
        .fire     (fire)
    );

    wdog_pulse #(
        .CODE_W (CODE_W)
    ) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire_i (fire),
        .code_i (cfg.code),
        .busy_o (busy),
        .done_o (done)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL):  bus_rdata = DATA_W'({cfg.code, cfg.mode, cfg.en});
            ADDR_W'(OFS_RANGE): bus_rdata = DATA_W'(cfg.idx);
            ADDR_W'(OFS_COUNT): bus_rdata = DATA_W'(cnt_val);
            ADDR_W'(OFS_STAT):  bus_rdata = DATA_W'(irq);
            default:            bus_rdata = '0;
        endcase
    end

    assign irq_o     = irq;
    assign sys_rst_o = busy;
endmodule

// File: rtl/wdog_timer_chk.sv
`timescale 1ns/1ps
module wdog_timer_chk #(
    parameter int BASE_LOG = 16,
    parameter int CNT_W    = 31
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             mode,
    input logic [CNT_W-1:0] cnt,
    input logic             irq,
    input logic             sys_rst,
    input logic             feed_ok
);
    localparam logic [CNT_W-1:0] IDLE_VAL = CNT_W'((64'd1 << BASE_LOG) - 1);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !en |-> (cnt == IDLE_VAL) && !sys_rst);

    p_sticky_en_r3: assert property (@(posedge clk) disable iff (rst)
        en |=> en);

    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        en && !sys_rst && (cnt != '0) && !feed_ok |=> cnt == $past(cnt) - CNT_W'(1));

    p_pulse_min_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst) |=> sys_rst);

    p_second_expiry_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst) && $past(mode) |-> $past(irq));

    p_key_clears_irq_r11: assert property (@(posedge clk) disable iff (rst)
        feed_ok |=> !irq);
endmodule

bind wdog_timer wdog_timer_chk #(
    .BASE_LOG (BASE_LOG),
    .CNT_W    (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (cfg.en),
    .mode    (cfg.mode),
    .cnt     (cnt_val),
    .irq     (irq),
    .sys_rst (sys_rst_o),
    .feed_ok (feed_ok)
);

// File: tb/wdog_timer_bench.sv
`timescale 1ns/1ps
module wdog_timer_bench;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_o, sys_rst_o;

    logic probe = 1'b0;
    int   probe_kind = 0;
    int   tests = 0;
    int   fails = 0;
    logic finished = 1'b0;

    typedef struct {
        logic [DATA_W-1:0] exp;
        string             tag;
    } item_t;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    wdog_timer #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .BASE_LOG (4)
    ) u_wdog_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .sys_rst_o (sys_rst_o)
    );

    // Driver tasks: each starts at a falling edge and uses one cycle.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                          input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    // kind 1 = sys_rst_o, kind 2 = irq_o
    task automatic pin_exp(input int kind, input logic e, input string tag);
        item_t it;
        it.exp = DATA_W'(e); it.tag = tag;
        sb_q.push_back(it);
        probe = 1'b1; probe_kind = kind;
        @(negedge clk);
        probe = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // Monitor: pops one expected item per observed access or probe.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if ((bus_sel && !bus_wr) || probe) begin
                logic [DATA_W-1:0] got;
                item_t it;
                if (probe) got = DATA_W'(probe_kind == 1 ? sys_rst_o : irq_o);
                else       got = bus_rdata;
                tests++;
                if (sb_q.size() == 0) begin
                    fails++;
                    $display("FAIL scoreboard empty: got %h expected none", got);
                end else begin
                    it = sb_q.pop_front();
                    if (got !== it.exp) begin
                        fails++;
                        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (30000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired: got 0 expected 1 (run completion)");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // Reset state and map (R1, R2)
        rd_exp(8'h00, 32'h0, "R1 ctrl after reset");
        rd_exp(8'h04, 32'h0, "R1 range after reset");
        rd_exp(8'h08, 32'd15, "R1 count after reset");
        rd_exp(8'h10, 32'h0, "R1 status after reset");
        rd_exp(8'h18, 32'h0, "R2 undefined offset");
        pin_exp(1, 1'b0, "R1 sys_rst low");
        pin_exp(2, 1'b0, "R1 irq low");
        wr(8'h04, 32'h2);
        rd_exp(8'h04, 32'h2, "R2 range readback");
        wr(8'h00, 32'h0C);
        rd_exp(8'h00, 32'h0C, "R2 ctrl readback");
        rd_exp(8'h08, 32'd15, "R1 count held while disabled");
        // Enable with range 2 -> reload 63 (R4)
        wr(8'h00, 32'h0D);
        rd_exp(8'h08, 32'd63, "R4 load on enable");
        rd_exp(8'h08, 32'd62, "R4 decrement");
        rd_exp(8'h08, 32'd61, "R4 decrement");
        wr(8'h00, 32'h0C);
        rd_exp(8'h00, 32'h0D, "R3 enable sticky");
        rd_exp(8'h08, 32'd58, "R3 still counting");
        wr(8'h0C, 32'h75);
        rd_exp(8'h08, 32'd56, "R5 wrong key ignored");
        wr(8'h0C, 32'h1276);
        rd_exp(8'h08, 32'd63, "R5 key reloads");
        wr(8'h04, 32'h0);
        rd_exp(8'h08, 32'd61, "R6 range write defers");
        wr(8'h0C, 32'h76);
        rd_exp(8'h08, 32'd15, "R6 new range at reload");
        // Mode 0 expiry, code 3 -> 16-cycle pulse (R7, R8)
        idle(14);
        pin_exp(1, 1'b0, "R7 no reset while count at zero");
        pin_exp(1, 1'b1, "R7 reset pulse starts");
        rd_exp(8'h08, 32'd0, "R7 count held in pulse");
        idle(13);
        pin_exp(1, 1'b1, "R7 pulse last cycle");
        pin_exp(1, 1'b0, "R7 pulse length");
        rd_exp(8'h08, 32'd14, "R8 reload after pulse");
        // Mode 1, code 0 -> 2-cycle pulse (R9, R10, R11)
        wr(8'h00, 32'h03);
        wr(8'h0C, 32'h76);
        idle(15);
        pin_exp(2, 1'b0, "R9 irq before expiry");
        pin_exp(2, 1'b1, "R9 irq on first expiry");
        pin_exp(1, 1'b0, "R9 no reset on first expiry");
        rd_exp(8'h10, 32'h1, "R9 status bit");
        rd_exp(8'h08, 32'd12, "R9 reload on first expiry");
        idle(11);
        pin_exp(1, 1'b0, "R10 before second expiry");
        pin_exp(1, 1'b1, "R10 reset on second expiry");
        pin_exp(1, 1'b1, "R10 pulse second cycle");
        pin_exp(1, 1'b0, "R10 pulse ends");
        rd_exp(8'h10, 32'h1, "R10 irq stays pending");
        rd_exp(8'h14, 32'h0, "R2 clear reads zero");
        rd_exp(8'h10, 32'h0, "R11 read clears irq");
        idle(12);
        pin_exp(2, 1'b1, "R9 irq set again");
        wr(8'h0C, 32'h76);
        rd_exp(8'h10, 32'h0, "R11 key clears irq");
        rd_exp(8'h08, 32'd14, "R11 key reloads");
        // Only reset disables (R3, R1)
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        rd_exp(8'h00, 32'h0, "R3 reset disables");
        rd_exp(8'h08, 32'd15, "R1 count after second reset");
        idle(3);
        rd_exp(8'h08, 32'd15, "R1 count holds");
        pin_exp(1, 1'b0, "R1 sys_rst low after reset");
        idle(2);
        if (sb_q.size() != 0) begin
            tests++;
            fails++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
        end
        finished = 1'b1;
        summary();
        $finish;
    end
endmodule